// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a timer peripheral for a small 8-bit controller. A fixed divide-by-12 stage turns the system clock into a slow tick. That tick steps a 7-bit down-counting prescaler. A three-bit select code picks either the slow tick itself or one bit of the prescaler. The chosen source steps an 8-bit down-counter. When the counter arrives at zero, a sticky zero flag is set. If the interrupt enable is also set, a level interrupt request is driven.

Software reaches the block through a simple register bus with a write strobe and a combinational read mux. The counter is at address D3h and can be read and written. The prescaler is at D2h; it can always be read, and it can be written only while running. The status/control register is at D4h. Everything runs on one clock, and every divided rate is a single-cycle enable pulse.

Top module: `pscl_timer`

## Requirements
- R1: After reset, the counter reads 00h, the prescaler reads 7Fh, the control register reads 00h and `irq` is low.
- R2: While the run bit (control bit 3) is 0, the prescaler is held at 7Fh, writes to it are ignored, and the counter does not decrement. The counter can still be written.
- R3: While the run bit is 1, the prescaler decrements by one, wrapping from 00h to 7Fh, exactly once every 12 clock cycles.
- R4: Select code s (control bits 2..0) makes the counter decrement once every 12·2^s cycles. Code 0 follows the divide-by-12 tick. Code s≥1 follows the 0-to-1 transitions of prescaler bit s-1.
- R5: While the run bit is 1, a write to address D2h loads the prescaler with bits 6..0 of the write data. Decrementing then continues from the loaded value.
- R6: A decrement from 00h gives FFh.
- R7: When a decrement brings the counter to 00h, the zero flag (control bit 7) is set. It stays set until software writes 0 to it. `irq` is high exactly when both the zero flag and the enable bit (control bit 6) are set.
- R8: A counter write in the same cycle as a decrement wins: the counter takes the written value.
- R9: Control bits 5..4 are plain read/write storage and have no effect on the timer.
- R10: A read from any address other than D2h, D3h and D4h returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for `bus_en` |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on `bus_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions check these properties on every cycle:
- the prescaler is frozen while stopped, and it decrements by one on each slow tick while running;
- counter ticks occur only on slow ticks;
- the counter wraps from zero to FFh;
- the zero flag is set on arrival at zero and is sticky;
- a counter write takes priority.

Only the bench scenarios can show the absolute rates: the exact interval between counter steps for each of the eight select codes. They also show prescaler loading and readback, the interrupt gating as seen at the pin, the spare control bits and the unmapped reads.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic             tmz;
    logic             eti;
    logic [1:0]       spare;
    logic             run;
    logic [SEL_W-1:0] sel;
  } ctl_t;

  typedef enum logic [1:0] {
    RS_NONE,
    RS_PSC,
    RS_CNT,
    RS_CTL
  } reg_sel_e;
endpackage

// File: rtl/tmr_basediv.sv
module tmr_basediv #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] phase_q;

  assign tick = (phase_q == CW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= '0;
    else if (tick) phase_q <= '0;
    else           phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 7,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  input  logic             run,
  input  logic             wr_en,
  input  logic [PSC_W-1:0] wr_data,
  input  logic [SEL_W-1:0] sel,
  output logic [PSC_W-1:0] psc,
  output logic             tap_tick
);
  // A tap fires when decrementing the current value turns bit (s-1) from 0 to 1.
  function automatic logic tap_rise(input logic [PSC_W-1:0] cur,
                                    input logic [SEL_W-1:0] s);
    logic [PSC_W-1:0] nx;
    logic             r;
    nx = cur - 1'b1;
    r  = (s == '0);
    for (int k = 1; k <= PSC_W; k++) begin
      if (int'(s) == k) r = !cur[k-1] && nx[k-1];
    end
    return r;
  endfunction

  logic [PSC_W-1:0] psc_q;
  logic             load;
  logic             step;

  assign load     = run && wr_en;
  assign step     = run && base_tick && !load;
  assign tap_tick = step && tap_rise(psc_q, sel);
  assign psc      = psc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    psc_q <= '1;
    else if (!run) psc_q <= '1;
    else if (load) psc_q <= wr_data;
    else if (step) psc_q <= psc_q - 1'b1;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic             zero_hit
);
  function automatic logic lands_on_zero(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_q;

  assign zero_hit = tick && !wr_en && lands_on_zero(cnt_q);
  assign cnt      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (wr_en) cnt_q <= wr_data;
    else if (tick)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
  import ptmr_pkg::*;
#(
  parameter int          BASE_DIV = 12,
  parameter int          PSC_W    = 7,
  parameter int          CNT_W    = 8,
  parameter logic [7:0]  A_PSC    = 8'hD2,
  parameter logic [7:0]  A_CNT    = 8'hD3,
  parameter logic [7:0]  A_CTL    = 8'hD4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_en,
  input  logic       bus_we,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq
);
  reg_sel_e   rsel;
  ctl_t       ctl_q;
  ctl_t       wr_ctl;
  logic       wr_any;
  logic       psc_wr, cnt_wr, ctl_wr;
  logic       base_tick, cnt_tick, zero_hit;
  logic       psi_on, tmz_on;
  logic [PSC_W-1:0] psc;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    if      (bus_addr == A_PSC) rsel = RS_PSC;
    else if (bus_addr == A_CNT) rsel = RS_CNT;
    else if (bus_addr == A_CTL) rsel = RS_CTL;
    else                        rsel = RS_NONE;
  end

  assign wr_any = bus_en && bus_we;
  assign psc_wr = wr_any && (rsel == RS_PSC);
  assign cnt_wr = wr_any && (rsel == RS_CNT);
  assign ctl_wr = wr_any && (rsel == RS_CTL);
  assign wr_ctl = ctl_t'(bus_wdata);
  assign psi_on = ctl_q.run;
  assign tmz_on = ctl_q.tmz;

  tmr_basediv #(.DIV(BASE_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (base_tick)
  );

  tmr_prescaler #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .base_tick(base_tick),
    .run      (psi_on),
    .wr_en    (psc_wr),
    .wr_data  (bus_wdata[PSC_W-1:0]),
    .sel      (ctl_q.sel),
    .psc      (psc),
    .tap_tick (cnt_tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (cnt_tick),
    .wr_en   (cnt_wr),
    .wr_data (bus_wdata[CNT_W-1:0]),
    .cnt     (cnt),
    .zero_hit(zero_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_wr) begin
      ctl_q     <= wr_ctl;
      ctl_q.tmz <= wr_ctl.tmz || zero_hit;
    end else if (zero_hit) begin
      ctl_q.tmz <= 1'b1;
    end
  end

  always_comb begin
    unique case (rsel)
      RS_PSC:  bus_rdata = 8'(psc);
      RS_CNT:  bus_rdata = 8'(cnt);
      RS_CTL:  bus_rdata = ctl_q;
      default: bus_rdata = 8'h00;
    endcase
  end

  assign irq = tmz_on && ctl_q.eti;
endmodule

// File: rtl/ptmr_chk.sv
module ptmr_chk #(
  parameter int PSC_W = 7,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             base_tick,
  input logic             cnt_tick,
  input logic             zero_hit,
  input logic             cnt_wr,
  input logic             psc_wr,
  input logic             ctl_wr,
  input logic [CNT_W-1:0] wdata,
  input logic             psi_on,
  input logic             tmz_on,
  input logic [PSC_W-1:0] psc,
  input logic [CNT_W-1:0] cnt
);
  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !psi_on |=> psc == {PSC_W{1'b1}});

  p_no_tick_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !psi_on |-> !cnt_tick);

  p_psc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (base_tick && psi_on && !psc_wr) |=> psc == PSC_W'($past(psc) - 1'b1));

  p_base_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |=> !base_tick);

  p_tick_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_tick |-> base_tick);

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !cnt_wr && cnt == '0) |=> cnt == {CNT_W{1'b1}});

  p_tmz_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    zero_hit |=> tmz_on);

  p_tmz_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmz_on && !ctl_wr) |=> tmz_on);

  p_wr_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt == $past(wdata));
endmodule

bind pscl_timer ptmr_chk #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .base_tick(base_tick),
  .cnt_tick (cnt_tick),
  .zero_hit (zero_hit),
  .cnt_wr   (cnt_wr),
  .psc_wr   (psc_wr),
  .ctl_wr   (ctl_wr),
  .wdata    (bus_wdata[CNT_W-1:0]),
  .psi_on   (psi_on),
  .tmz_on   (tmz_on),
  .psc      (psc),
  .cnt      (cnt)
);

// File: tb/sim_pscl_timer.sv
module sim_pscl_timer;
  localparam logic [7:0] A_PSC = 8'hD2;
  localparam logic [7:0] A_CNT = 8'hD3;
  localparam logic [7:0] A_CTL = 8'hD4;
  localparam int         BASE  = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  pscl_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int v, a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(A_CNT, v); chk("R1 cnt", v, 0);
    rd(A_PSC, v); chk("R1 psc", v, 8'h7F);
    rd(A_CTL, v); chk("R1 ctl", v, 0);
    chk("R1 irq", int'(irq), 0);

    // R2 stopped: frozen prescaler, no counting, counter still writable
    wr(A_CNT, 8'h10);
    wr(A_PSC, 8'h05);
    repeat (100) @(negedge clk);
    rd(A_CNT, v); chk("R2 cnt held", v, 8'h10);
    rd(A_PSC, v); chk("R2 psc write ignored", v, 8'h7F);

    // R9 spare control bits, timer still stopped
    wr(A_CTL, 8'h37);
    rd(A_CTL, v); chk("R9 spare bits", v, 8'h37);
    repeat (50) @(negedge clk);
    rd(A_CNT, v); chk("R9 no effect", v, 8'h10);

    // R10 unmapped addresses
    rd(8'h00, v); chk("R10 addr 00", v, 0);
    rd(8'hD5, v); chk("R10 addr D5", v, 0);
    rd(8'hD1, v); chk("R10 addr D1", v, 0);

    // R3 prescaler rate
    wr(A_CTL, 8'h0F);
    rd(A_PSC, a);
    repeat (2 * BASE) @(negedge clk);
    rd(A_PSC, b); chk("R3 two steps", b, (a - 2) & 8'h7F);
    repeat (5 * BASE) @(negedge clk);
    rd(A_PSC, v); chk("R3 seven steps", v, (a - 7) & 8'h7F);

    // R5 prescaler load while running
    wr(A_PSC, 8'h33);
    rd(A_PSC, v); chk("R5 load", v, 8'h33);
    repeat (BASE) @(negedge clk);
    rd(A_PSC, v); chk("R5 continue", v, 8'h32);
    wr(A_PSC, 8'h00);
    repeat (BASE) @(negedge clk);
    rd(A_PSC, v); chk("R3 wrap 00 to 7F", v, 8'h7F);

    // R4 interval per select code
    for (int s = 0; s < 8; s++) begin
      int t [3];
      int seen, prev, cyc;
      wr(A_CTL, 8'(s));
      wr(A_CNT, 8'd5);
      wr(A_CTL, 8'(8 | s));
      seen = 0; prev = 5; cyc = 0;
      bus_addr = A_CNT;
      while (seen < 3 && cyc < 4 * BASE * 128 + 100) begin
        @(negedge clk); cyc++;
        #1 v = int'(bus_rdata);
        if (v != prev) begin t[seen] = cyc; seen++; prev = v; end
      end
      chk($sformatf("R4 code %0d steps", s), seen, 3);
      chk($sformatf("R4 code %0d gap a", s), t[1] - t[0], BASE << s);
      chk($sformatf("R4 code %0d gap b", s), t[2] - t[1], BASE << s);
      chk($sformatf("R4 code %0d value", s), prev, 2);
    end

    // R6/R7 arrival at zero, sticky flag, wrap, interrupt gating
    wr(A_CTL, 8'h00);
    wr(A_CNT, 8'd2);
    wr(A_CTL, 8'h08);
    bus_addr = A_CNT;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      #1 v = int'(bus_rdata);
      if (v == 0) break;
    end
    chk("R7 reached zero", v, 0);
    rd(A_CTL, v); chk("R7 flag set", v >> 7, 1);
    chk("R7 irq masked", int'(irq), 0);
    bus_addr = A_CNT;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      #1 v = int'(bus_rdata);
      if (v != 0) break;
    end
    chk("R6 wrap to FF", v, 8'hFF);
    rd(A_CTL, v); chk("R7 flag sticky", v >> 7, 1);
    wr(A_CTL, 8'hC8);
    chk("R7 irq raised", int'(irq), 1);
    wr(A_CTL, 8'h48);
    chk("R7 irq cleared", int'(irq), 0);
    rd(A_CTL, v); chk("R7 flag cleared", v >> 7, 0);

    // R8 write collides with a decrement
    wr(A_CTL, 8'h08);
    wr(A_CNT, 8'd200);
    bus_addr = A_CNT;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      #1 v = int'(bus_rdata);
      if (v != 200) break;
    end
    chk("R8 sync", v, 199);
    repeat (BASE - 1) @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = A_CNT; bus_wdata = 8'h40;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    rd(A_CNT, v); chk("R8 write wins", v, 8'h40);
    repeat (BASE - 1) @(negedge clk);
    rd(A_CNT, v); chk("R8 held", v, 8'h40);
    @(negedge clk);
    rd(A_CNT, v); chk("R8 next step", v, 8'h3F);

    finish_run();
  end
endmodule